// File: doc/BRIEF.md
# Fuse-Driven Steering Target Resolver

This block answers one question for a register bus that fronts replicated register copies: for a given register address, which group and instance must the steering selector carry so that a read reaches a copy that is present and powered? Each steering class owns a set of inclusive address ranges and one precomputed group/instance target. A lookup tests the address against every class. The first class in a fixed priority order that matches supplies the result. If no class matches, the address may fall in an implicitly steered range, which needs no steering at all. An address that matches nothing gets a default target and a miss flag.

The targets come from fuse enable masks. After reset the block waits for a start pulse. It then takes a snapshot of the masks and walks their bits one per cycle, recording the lowest enabled memory slice, cache bank, node and compute unit. In the next cycle it applies per-class arithmetic to those indices. The bank rule and the number of units per group are set by a variant parameter. A configured units-per-group value overrides the variant's fallback. Lookups are accepted only while `ready` is high, and their results are registered.

Control states:
- `ST_IDLE`: holds after reset.
- `ST_SCAN`: walks one mask bit per cycle.
- `ST_CALC`: forms the targets.
- `ST_READY`: lookups are served.

Transitions:
- IDLE→SCAN on `start`.
- SCAN→CALC when the last bit has been walked.
- CALC→READY unconditionally.
- READY→SCAN on `start`, which recomputes the targets from the current masks.

Top module: `steer_resolver`

## Requirements
- R1: After reset `ready` is low. After a `start` pulse, `ready` rises within SCAN_LEN+4 clock cycles, where SCAN_LEN is the widest mask width.
- R2: A lookup presented on a clock edge with `ready` high gives `res_valid` high after that edge, with the result. A lookup while `ready` is low is ignored, and `res_valid` stays low.
- R3: Classes are searched in the priority order bank, slice, node, unit, node-select. Range limits are inclusive. The ranges are:
  - bank: 0x0B100–0x0B3FF
  - slice: 0x0DD00–0x0DDFF and 0x0B200–0x0B2FF
  - node: 0x0B000–0x0B0FF and 0x0D880–0x0D8FF
  - unit: 0x05200–0x052FF and 0x0DE80–0x0E8FF
  - node-select: 0x01000–0x01FFF
- R4: The implicit ranges are 0x04000–0x04AFF, 0x0C800–0x0CFFF and 0x0DD00–0x0DD7F. An address in one of them that matches no class gives `res_steer`=0 and `res_miss`=0. A class match takes precedence over an implicit match.
- R5: An address that matches no range gives group 0, instance 0, `res_steer`=1 and `res_miss`=1.
- R6: With s the lowest set bit index of `slice_en_mask`, the slice class target is group s, instance 0. The node class target is group s<<1, instance 0.
- R7: With VARIANT=1, the bank class target is group ((s*8)>>2)&7 and instance (s*8)&3.
- R8: With VARIANT=2, the bank class target is group s. Its instance is 0 when `bank_en_mask` bit 0 is set, and 2 otherwise.
- R9: With d the lowest set bit index of `unit_en_mask`, the unit class target is group d/N, instance d%N. N is UNITS_PER_GRP when that is non-zero. Otherwise N is 6, 4 or 8 for VARIANT 0, 1 or 2.
- R10: With n the lowest set bit index of `node_en_mask`, the node-select target is group n>>1, instance n&1.
- R11: An all-zero mask yields index 0 for its class arithmetic.
- R12: Targets hold while `ready` is high, whatever the masks do. A `start` pulse in the ready state recomputes them from the masks present at that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that snapshots the masks and recomputes the targets |
| slice_en_mask | input | SLICE_W | Memory-slice enable fuses |
| bank_en_mask | input | BANK_W | Cache-bank enable fuses |
| node_en_mask | input | NODE_W | Node enable fuses |
| unit_en_mask | input | UNIT_W | Compute-unit enable fuses |
| ready | output | 1 | Targets valid; lookups accepted |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | ADDR_W | Register address to resolve |
| res_valid | output | 1 | Result registered from the previous cycle's lookup |
| res_group | output | GRP_W | Steering group |
| res_inst | output | INST_W | Steering instance |
| res_steer | output | 1 | Steering selector must be programmed |
| res_miss | output | 1 | Address matched no range |

## Verification
The bench builds two copies side by side from one set of stimuli:
- VARIANT=1 with UNITS_PER_GRP=0, which exercises the slice-times-eight bank arithmetic and the four-per-group fallback.
- VARIANT=2 with UNITS_PER_GRP=3, which exercises the bank-mask bit-0 rule and an explicit divisor that leaves a non-zero quotient with remainder 0.

The chosen masks place the lowest unit at indices 6 and 15. That brings both division results and the wrap to a high group within reach. An empty node mask and a bank mask without bit 0 cover the default-index and alternate-instance corners.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_CLS = 5;
    localparam int C_BANK  = 0;
    localparam int C_SLICE = 1;
    localparam int C_NODE  = 2;
    localparam int C_UNIT  = 3;
    localparam int C_NSEL  = 4;

    localparam int NUM_RNG = 8;
    localparam int NUM_IMP = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CALC,
        ST_READY
    } steer_state_e;

    function automatic logic [31:0] rng_lo(input int k);
        case (k)
            0: rng_lo = 32'h0B100;
            1: rng_lo = 32'h0DD00;
            2: rng_lo = 32'h0B200;
            3: rng_lo = 32'h0B000;
            4: rng_lo = 32'h0D880;
            5: rng_lo = 32'h05200;
            6: rng_lo = 32'h0DE80;
            7: rng_lo = 32'h01000;
            default: rng_lo = 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic logic [31:0] rng_hi(input int k);
        case (k)
            0: rng_hi = 32'h0B3FF;
            1: rng_hi = 32'h0DDFF;
            2: rng_hi = 32'h0B2FF;
            3: rng_hi = 32'h0B0FF;
            4: rng_hi = 32'h0D8FF;
            5: rng_hi = 32'h052FF;
            6: rng_hi = 32'h0E8FF;
            7: rng_hi = 32'h01FFF;
            default: rng_hi = 32'h0;
        endcase
    endfunction

    function automatic int rng_cls(input int k);
        case (k)
            0:       rng_cls = C_BANK;
            1, 2:    rng_cls = C_SLICE;
            3, 4:    rng_cls = C_NODE;
            5, 6:    rng_cls = C_UNIT;
            default: rng_cls = C_NSEL;
        endcase
    endfunction

    function automatic logic [31:0] imp_lo(input int k);
        case (k)
            0: imp_lo = 32'h04000;
            1: imp_lo = 32'h0C800;
            2: imp_lo = 32'h0DD00;
            default: imp_lo = 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic logic [31:0] imp_hi(input int k);
        case (k)
            0: imp_hi = 32'h04AFF;
            1: imp_hi = 32'h0CFFF;
            2: imp_hi = 32'h0DD7F;
            default: imp_hi = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/steer_range_match.sv
module steer_range_match
    import steer_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CLS-1:0] cls_sel,
    output logic               imp_hit
);

    logic [31:0]        a32;
    logic [NUM_RNG-1:0] rng_hit;
    logic [NUM_IMP-1:0] imp_v;
    logic [NUM_CLS-1:0] cls_raw;

    assign a32 = 32'(addr);

    // inclusive compare per class range
    generate
        for (genvar k = 0; k < NUM_RNG; k++) begin : g_rng
            assign rng_hit[k] = (a32 >= rng_lo(k)) && (a32 <= rng_hi(k));
        end
        for (genvar k = 0; k < NUM_IMP; k++) begin : g_imp
            assign imp_v[k] = (a32 >= imp_lo(k)) && (a32 <= imp_hi(k));
        end
    endgenerate

    assign imp_hit = |imp_v;

    always_comb begin
        cls_raw = '0;
        for (int k = 0; k < NUM_RNG; k++) begin
            if (rng_hit[k]) cls_raw[rng_cls(k)] = 1'b1;
        end
    end

    // fixed priority: lowest class index wins
    always_comb begin
        logic taken;
        taken   = 1'b0;
        cls_sel = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (!taken && cls_raw[c]) begin
                cls_sel[c] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

    always_comb begin
        a_r3_single_class: assert ($onehot0(cls_sel));
    end

endmodule

// File: rtl/steer_target_fsm.sv
module steer_target_fsm
    import steer_pkg::*;
#(
    parameter int SLICE_W       = 4,
    parameter int BANK_W        = 3,
    parameter int NODE_W        = 4,
    parameter int UNIT_W        = 16,
    parameter int GRP_W         = 4,
    parameter int INST_W        = 4,
    parameter int VARIANT       = 1,
    parameter int UNITS_PER_GRP = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [SLICE_W-1:0]             slice_en_mask,
    input  logic [BANK_W-1:0]              bank_en_mask,
    input  logic [NODE_W-1:0]              node_en_mask,
    input  logic [UNIT_W-1:0]              unit_en_mask,
    output logic                           ready,
    output logic [NUM_CLS-1:0][GRP_W-1:0]  grp_tgt,
    output logic [NUM_CLS-1:0][INST_W-1:0] inst_tgt
);

    localparam int MAX_SB   = (SLICE_W > BANK_W) ? SLICE_W : BANK_W;
    localparam int MAX_NU   = (NODE_W > UNIT_W) ? NODE_W : UNIT_W;
    localparam int SCAN_LEN = (MAX_SB > MAX_NU) ? MAX_SB : MAX_NU;
    localparam int CNT_W    = $clog2(SCAN_LEN + 1);
    localparam int SNAP_W   = 1 << CNT_W;
    localparam int EFF_N    = (UNITS_PER_GRP > 0) ? UNITS_PER_GRP :
                              (VARIANT == 2) ? 8 : (VARIANT == 1) ? 4 : 6;

    steer_state_e state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [SNAP_W-1:0] snap_s, snap_b, snap_n, snap_u;
    logic              f_s, f_b, f_n, f_u;
    logic [CNT_W-1:0]  idx_s, idx_b, idx_n, idx_u;

    logic [31:0] s32, b32, n32, u32, bank32;
    logic [NUM_CLS-1:0][GRP_W-1:0]  grp_c;
    logic [NUM_CLS-1:0][INST_W-1:0] inst_c;
    logic [GRP_W-1:0]  bank_grp;
    logic [INST_W-1:0] bank_inst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SCAN;
            ST_SCAN:  if (cnt == CNT_W'(SCAN_LEN - 1)) nxt = ST_CALC;
            ST_CALC:  nxt = ST_READY;
            ST_READY: if (start) nxt = ST_SCAN;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb ready = (state == ST_READY);

    // scan datapath: lowest set bit of each mask, one bit per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            snap_s <= '0; snap_b <= '0; snap_n <= '0; snap_u <= '0;
            f_s    <= 1'b0; f_b <= 1'b0; f_n <= 1'b0; f_u <= 1'b0;
            idx_s  <= '0; idx_b <= '0; idx_n <= '0; idx_u <= '0;
            grp_tgt  <= '0;
            inst_tgt <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_READY: begin
                    if (start) begin
                        cnt    <= '0;
                        snap_s <= SNAP_W'(slice_en_mask);
                        snap_b <= SNAP_W'(bank_en_mask);
                        snap_n <= SNAP_W'(node_en_mask);
                        snap_u <= SNAP_W'(unit_en_mask);
                        f_s <= 1'b0; f_b <= 1'b0; f_n <= 1'b0; f_u <= 1'b0;
                        idx_s <= '0; idx_b <= '0; idx_n <= '0; idx_u <= '0;
                    end
                end
                ST_SCAN: begin
                    cnt <= cnt + 1'b1;
                    if (!f_s && snap_s[cnt]) begin f_s <= 1'b1; idx_s <= cnt; end
                    if (!f_b && snap_b[cnt]) begin f_b <= 1'b1; idx_b <= cnt; end
                    if (!f_n && snap_n[cnt]) begin f_n <= 1'b1; idx_n <= cnt; end
                    if (!f_u && snap_u[cnt]) begin f_u <= 1'b1; idx_u <= cnt; end
                end
                ST_CALC: begin
                    grp_tgt  <= grp_c;
                    inst_tgt <= inst_c;
                end
                default: ;
            endcase
        end
    end

    assign s32    = 32'(idx_s);
    assign b32    = 32'(idx_b);
    assign n32    = 32'(idx_n);
    assign u32    = 32'(idx_u);
    assign bank32 = s32 << 3;

    // bank rule picked by variant
    generate
        if (VARIANT == 1) begin : g_bank_quad
            assign bank_grp  = GRP_W'((bank32 >> 2) & 32'd7);
            assign bank_inst = INST_W'(bank32 & 32'd3);
        end else if (VARIANT == 2) begin : g_bank_bit0
            assign bank_grp  = GRP_W'(s32);
            assign bank_inst = snap_b[0] ? INST_W'(0) : INST_W'(2);
        end else begin : g_bank_first
            assign bank_grp  = '0;
            assign bank_inst = INST_W'(b32);
        end
    endgenerate

    always_comb begin
        grp_c  = '0;
        inst_c = '0;
        grp_c[C_BANK]   = bank_grp;
        inst_c[C_BANK]  = bank_inst;
        grp_c[C_SLICE]  = GRP_W'(s32);
        grp_c[C_NODE]   = GRP_W'(s32 << 1);
        grp_c[C_UNIT]   = GRP_W'(u32 / EFF_N);
        inst_c[C_UNIT]  = INST_W'(u32 % EFF_N);
        grp_c[C_NSEL]   = GRP_W'(n32 >> 1);
        inst_c[C_NSEL]  = INST_W'(n32 & 32'd1);
    end

    a_r1_calc_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CALC |=> ready);
    a_r1_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SCAN |-> cnt < CNT_W'(SCAN_LEN));
    a_r12_hold_targets: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ($stable(grp_tgt) && $stable(inst_tgt)));
    a_r12_start_rescans: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (state == ST_SCAN));

endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
    import steer_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int SLICE_W       = 4,
    parameter int BANK_W        = 3,
    parameter int NODE_W        = 4,
    parameter int UNIT_W        = 16,
    parameter int GRP_W         = 4,
    parameter int INST_W        = 4,
    parameter int VARIANT       = 1,
    parameter int UNITS_PER_GRP = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SLICE_W-1:0] slice_en_mask,
    input  logic [BANK_W-1:0]  bank_en_mask,
    input  logic [NODE_W-1:0]  node_en_mask,
    input  logic [UNIT_W-1:0]  unit_en_mask,
    output logic               ready,
    input  logic               lookup_valid,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic               res_valid,
    output logic [GRP_W-1:0]   res_group,
    output logic [INST_W-1:0]  res_inst,
    output logic               res_steer,
    output logic               res_miss
);

    logic [NUM_CLS-1:0][GRP_W-1:0]  grp_tgt;
    logic [NUM_CLS-1:0][INST_W-1:0] inst_tgt;
    logic [NUM_CLS-1:0] cls_sel;
    logic               imp_hit;
    logic               any_cls;
    logic [GRP_W-1:0]   sel_grp;
    logic [INST_W-1:0]  sel_inst;

    steer_target_fsm #(
        .SLICE_W(SLICE_W), .BANK_W(BANK_W), .NODE_W(NODE_W), .UNIT_W(UNIT_W),
        .GRP_W(GRP_W), .INST_W(INST_W), .VARIANT(VARIANT),
        .UNITS_PER_GRP(UNITS_PER_GRP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slice_en_mask(slice_en_mask), .bank_en_mask(bank_en_mask),
        .node_en_mask(node_en_mask), .unit_en_mask(unit_en_mask),
        .ready(ready), .grp_tgt(grp_tgt), .inst_tgt(inst_tgt)
    );

    steer_range_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(lookup_addr), .cls_sel(cls_sel), .imp_hit(imp_hit)
    );

    assign any_cls = |cls_sel;

    always_comb begin
        sel_grp  = '0;
        sel_inst = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (cls_sel[c]) begin
                sel_grp  = grp_tgt[c];
                sel_inst = inst_tgt[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_group <= '0;
            res_inst  <= '0;
            res_steer <= 1'b0;
            res_miss  <= 1'b0;
        end else begin
            res_valid <= lookup_valid && ready;
            if (lookup_valid && ready) begin
                res_group <= sel_grp;
                res_inst  <= sel_inst;
                res_steer <= any_cls || !imp_hit;
                res_miss  <= !any_cls && !imp_hit;
            end
        end
    end

    a_r2_gate_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !ready) |=> !res_valid);
    a_r5_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_steer && res_group == '0 && res_inst == '0));
    a_r4_implicit_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_steer) |-> !res_miss);

endmodule

// File: tb/steer_resolver_bench.sv
`timescale 1ns/1ps
module steer_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  slice_m = '0;
    logic [2:0]  bank_m = '0;
    logic [3:0]  node_m = '0;
    logic [15:0] unit_m = '0;
    logic        lv = 1'b0;
    logic [23:0] la = '0;

    logic        rdy1, v1, st1, ms1;
    logic [3:0]  g1, i1;
    logic        rdy2, v2, st2, ms2;
    logic [3:0]  g2, i2;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    steer_resolver #(.VARIANT(1), .UNITS_PER_GRP(0)) u_steer_resolver (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slice_en_mask(slice_m), .bank_en_mask(bank_m),
        .node_en_mask(node_m), .unit_en_mask(unit_m),
        .ready(rdy1), .lookup_valid(lv), .lookup_addr(la),
        .res_valid(v1), .res_group(g1), .res_inst(i1),
        .res_steer(st1), .res_miss(ms1)
    );

    steer_resolver #(.VARIANT(2), .UNITS_PER_GRP(3)) u_steer_resolver_v2 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slice_en_mask(slice_m), .bank_en_mask(bank_m),
        .node_en_mask(node_m), .unit_en_mask(unit_m),
        .ready(rdy2), .lookup_valid(lv), .lookup_addr(la),
        .res_valid(v2), .res_group(g2), .res_inst(i2),
        .res_steer(st2), .res_miss(ms2)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [23:0] addr);
        @(negedge clk);
        lv = 1'b1;
        la = addr;
        @(negedge clk);
        lv = 1'b0;
    endtask

    task automatic expect1(input string req, input int g, input int i,
                           input int st, input int ms);
        chk({req, " v1 valid"}, int'(v1), 1);
        chk({req, " v1 group"}, int'(g1), g);
        chk({req, " v1 inst"},  int'(i1), i);
        chk({req, " v1 steer"}, int'(st1), st);
        chk({req, " v1 miss"},  int'(ms1), ms);
    endtask

    task automatic expect2(input string req, input int g, input int i,
                           input int st, input int ms);
        chk({req, " v2 valid"}, int'(v2), 1);
        chk({req, " v2 group"}, int'(g2), g);
        chk({req, " v2 inst"},  int'(i2), i);
        chk({req, " v2 steer"}, int'(st2), st);
        chk({req, " v2 miss"},  int'(ms2), ms);
    endtask

    task automatic pulse_start_and_wait(input string req);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!(rdy1 && rdy2) && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " ready latency within bound"}, int'(cyc <= 20), 1);
    endtask

    task automatic t_reset();
        chk("R1 ready low after reset v1", int'(rdy1), 0);
        chk("R1 ready low after reset v2", int'(rdy2), 0);
        chk("R2 no result after reset", int'(v1 | v2), 0);
    endtask

    task automatic t_not_ready();
        lookup(24'h0B150);
        chk("R2 lookup ignored while not ready", int'(v1 | v2), 0);
    endtask

    task automatic t_first_targets();
        slice_m = 4'b0100;
        bank_m  = 3'b010;
        node_m  = 4'b1000;
        unit_m  = 16'h0040;
        pulse_start_and_wait("R1");
        lookup(24'h0B150);
        expect1("R7 bank quad rule", 4, 0, 1, 0);
        expect2("R8 bank bit0 clear", 2, 2, 1, 0);
        lookup(24'h0B250);
        expect1("R3 bank beats slice overlap", 4, 0, 1, 0);
        expect2("R3 bank beats slice overlap", 2, 2, 1, 0);
        lookup(24'h0B0FF);
        expect1("R3 R6 node range upper limit", 4, 0, 1, 0);
        lookup(24'h0DD10);
        expect1("R4 R6 slice beats implicit", 2, 0, 1, 0);
        lookup(24'h0E000);
        expect1("R9 unit fallback N4", 1, 2, 1, 0);
        expect2("R9 unit N3", 2, 0, 1, 0);
        lookup(24'h01800);
        expect1("R10 node select", 1, 1, 1, 0);
        lookup(24'h0C900);
        expect1("R4 implicit no steer", 0, 0, 0, 0);
        lookup(24'h0DE7F);
        expect1("R5 miss default", 0, 0, 1, 1);
        expect2("R5 miss default", 0, 0, 1, 1);
    endtask

    task automatic t_hold();
        slice_m = 4'b0001;
        bank_m  = 3'b011;
        node_m  = 4'b0000;
        unit_m  = 16'h8000;
        repeat (3) @(negedge clk);
        lookup(24'h0DD10);
        expect1("R12 targets held without start", 2, 0, 1, 0);
    endtask

    task automatic t_recompute();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lv = 1'b1;
        la = 24'h0DD10;
        @(negedge clk);
        lv = 1'b0;
        chk("R2 lookup ignored during rescan", int'(v1 | v2), 0);
        repeat (25) @(negedge clk);
        chk("R12 ready after rescan", int'(rdy1 & rdy2), 1);
        lookup(24'h0DD10);
        expect1("R12 slice recomputed", 0, 0, 1, 0);
        lookup(24'h01800);
        expect1("R11 empty node mask", 0, 0, 1, 0);
        lookup(24'h0E000);
        expect1("R9 unit high index N4", 3, 3, 1, 0);
        expect2("R9 unit high index N3", 5, 0, 1, 0);
        lookup(24'h0B150);
        expect1("R7 bank slice zero", 0, 0, 1, 0);
        expect2("R8 bank bit0 set", 0, 0, 1, 0);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_not_ready();
        t_first_targets();
        t_hold();
        t_recompute();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule